// File: doc/BRIEF.md
# Serial Bus Clock and Line Control

This block produces the serial clock of a two-wire bus from a faster parent clock and tells the protocol sequencer when to change the data line. A sequencer raises `run` while it moves a transfer. During that time the block divides the parent clock down to a square wave on SCL. It marks each SCL edge with a one-cycle strobe. A programmable number of parent cycles after each falling edge it pulses a launch strobe, and the sequencer uses that pulse to put the next data bit on SDA. When `run` is low, the divider waits at zero and SCL sits high.

Software can take over either bus line through a line-control word, and this takes priority over the divider and the sequencer. The block also returns the live level of both pins through a two-flop synchronizer, so software can see what the wire is really doing, for example while it clears a stuck bus by hand. The bus clock must stay at or below 20 MHz. The integrator meets this by choosing the divider for the parent clock in use.

Top module: `sclk_line_ctrl`

## Requirements
- R1: With `run` high and no SCL override, SCL toggles every D+1 parent cycles, so the bus period is 2×(D+1), where D is `clk_cfg[7:0]`. The first falling edge appears on the (D+1)-th rising clock edge at which `run` is sampled high.
- R2: One cycle after `run` is sampled low, SCL is high and the divider count is zero. A later `run` therefore gives its first falling edge again after D+1 edges. With no override, `scl_oe` equals `run`.
- R3: `scl_fall` is high for exactly the first parent cycle in which the divided clock is low. `scl_rise` is high for exactly the first cycle in which it is high again. The two are never high together, and returning to idle gives no strobe.
- R4: `launch` pulses for one cycle N cycles after the cycle in which `scl_fall` is high. N is the delay field `clk_cfg[10:8]`, and a field value of 0 acts as 1.
- R5: The clock-control word has the divider in bits 7:0 and the launch delay in bits 10:8.
- R6: When `line_cfg[0]` is 1, `sda_oe` is 1 and `sda_out` equals `line_cfg[1]`, whatever the sequencer drives. Otherwise `sda_out` and `sda_oe` follow `seq_sda_out` and `seq_sda_oe`.
- R7: When `line_cfg[2]` is 1, `scl_oe` is 1 and `scl_out` equals `line_cfg[3]`, while the divider and its strobes keep running underneath.
- R8: `line_level[0]` is the SDA pin and `line_level[1]` is the SCL pin. Each shows the pin value sampled two rising clock edges earlier.
- R9: During reset, `scl_out` is 1, `scl_rise`, `scl_fall` and `launch` are 0, and `line_level` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cfg | input | 11 | Divider [7:0], launch delay [10:8] |
| line_cfg | input | 4 | SDA force enable/value [0]/[1], SCL force enable/value [2]/[3] |
| run | input | 1 | Transfer in progress, from the sequencer |
| seq_sda_out | input | 1 | SDA value requested by the sequencer |
| seq_sda_oe | input | 1 | SDA output enable requested by the sequencer |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_out | output | 1 | SCL drive value |
| scl_oe | output | 1 | SCL output enable |
| sda_out | output | 1 | SDA drive value |
| sda_oe | output | 1 | SDA output enable |
| scl_rise | output | 1 | One-cycle strobe on SCL rising edge |
| scl_fall | output | 1 | One-cycle strobe on SCL falling edge |
| launch | output | 1 | One-cycle data-launch strobe |
| line_level | output | 2 | Synchronized pin levels, [0] SDA, [1] SCL |

## Verification
The edge-level checks assume that `line_cfg[2]` is clear whenever the divided clock is compared with `scl_out`, since a forced SCL hides the divider. The stimulus leaves SCL forcing off during every timing measurement. The launch timing assumes that the effective delay is shorter than one full bus period, because otherwise the next falling edge would reload the timer first. The vector table keeps every delay below 2×(D+1). `clk_cfg` changes only while `run` is low, so no period ever mixes two divider values.

// File: rtl/sclk_line_pkg.sv
package sclk_line_pkg;
    localparam int DIV_W = 8;
    localparam int DLY_W = 3;
    localparam int CFG_W = DIV_W + DLY_W;

    // line_cfg bit positions
    localparam int SDA_FORCE_EN  = 0;
    localparam int SDA_FORCE_VAL = 1;
    localparam int SCL_FORCE_EN  = 2;
    localparam int SCL_FORCE_VAL = 3;

    // line_level bit positions
    localparam int LVL_SDA = 0;
    localparam int LVL_SCL = 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             scl;
        logic             rise;
        logic             fall;
    } div_state_t;

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             launch;
    } launch_state_t;

    typedef struct packed {
        logic [1:0] s1;
        logic [1:0] s2;
    } sync_state_t;
endpackage

// File: rtl/sclk_divider.sv
module sclk_divider
    import sclk_line_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             scl,
    output logic             rise,
    output logic             fall
);
    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
            st_d.scl = 1'b1;
        end else if (st_q.cnt == div) begin
            st_d.cnt  = '0;
            st_d.scl  = ~st_q.scl;
            st_d.rise = ~st_q.scl;
            st_d.fall = st_q.scl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, scl: 1'b1, rise: 1'b0, fall: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl  = st_q.scl;
    assign rise = st_q.rise;
    assign fall = st_q.fall;
endmodule

// File: rtl/sclk_launch.sv
module sclk_launch
    import sclk_line_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fall,
    input  logic [DLY_W-1:0] dly,
    output logic             launch
);
    launch_state_t st_d, st_q;
    logic [DLY_W-1:0] eff;

    // a zero delay field behaves as one cycle
    assign eff = (dly == '0) ? DLY_W'(1) : dly;

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (fall) begin
            st_d.cnt    = eff - 1'b1;
            st_d.launch = (eff == DLY_W'(1));
        end else if (st_q.cnt != '0) begin
            st_d.cnt    = st_q.cnt - 1'b1;
            st_d.launch = (st_q.cnt == DLY_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, launch: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign launch = st_q.launch;
endmodule

// File: rtl/sclk_line_io.sv
module sclk_line_io
    import sclk_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] line_cfg,
    input  logic       run,
    input  logic       div_scl,
    input  logic       seq_sda_out,
    input  logic       seq_sda_oe,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_out,
    output logic       scl_oe,
    output logic       sda_out,
    output logic       sda_oe,
    output logic [1:0] line_level
);
    sync_state_t st_d, st_q;
    logic [1:0]  pins;

    always_comb begin
        pins          = '0;
        pins[LVL_SDA] = sda_in;
        pins[LVL_SCL] = scl_in;
        st_d.s1       = pins;
        st_d.s2       = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 2'b11, s2: 2'b11};
        end else begin
            st_q <= st_d;
        end
    end

    // software forcing wins over divider and sequencer
    always_comb begin
        if (line_cfg[SCL_FORCE_EN]) begin
            scl_out = line_cfg[SCL_FORCE_VAL];
            scl_oe  = 1'b1;
        end else begin
            scl_out = div_scl;
            scl_oe  = run;
        end
        if (line_cfg[SDA_FORCE_EN]) begin
            sda_out = line_cfg[SDA_FORCE_VAL];
            sda_oe  = 1'b1;
        end else begin
            sda_out = seq_sda_out;
            sda_oe  = seq_sda_oe;
        end
    end

    assign line_level = st_q.s2;
endmodule

// File: rtl/sclk_line_ctrl.sv
module sclk_line_ctrl
    import sclk_line_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] clk_cfg,
    input  logic [3:0]       line_cfg,
    input  logic             run,
    input  logic             seq_sda_out,
    input  logic             seq_sda_oe,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_out,
    output logic             scl_oe,
    output logic             sda_out,
    output logic             sda_oe,
    output logic             scl_rise,
    output logic             scl_fall,
    output logic             launch,
    output logic [1:0]       line_level
);
    logic div_scl;

    sclk_divider i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (clk_cfg[DIV_W-1:0]),
        .scl   (div_scl),
        .rise  (scl_rise),
        .fall  (scl_fall)
    );

    sclk_launch i_launch (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .fall   (scl_fall),
        .dly    (clk_cfg[CFG_W-1:DIV_W]),
        .launch (launch)
    );

    sclk_line_io i_io (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_cfg    (line_cfg),
        .run         (run),
        .div_scl     (div_scl),
        .seq_sda_out (seq_sda_out),
        .seq_sda_oe  (seq_sda_oe),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .scl_out     (scl_out),
        .scl_oe      (scl_oe),
        .sda_out     (sda_out),
        .sda_oe      (sda_oe),
        .line_level  (line_level)
    );
endmodule

// File: rtl/sclk_line_ctrl_chk.sv
module sclk_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic [3:0] line_cfg,
    input logic       scl_out,
    input logic       scl_rise,
    input logic       scl_fall,
    input logic       scl_in,
    input logic       sda_in,
    input logic [1:0] line_level
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
    end

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (line_cfg[2] || scl_out));

    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall}));

    a_r3_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && !line_cfg[2]) |-> !scl_out);

    a_r3_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && !line_cfg[2]) |-> scl_out);

    a_r8_level_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (line_level == {$past(scl_in, 2), $past(sda_in, 2)}));
endmodule

bind sclk_line_ctrl sclk_line_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .line_cfg   (line_cfg),
    .scl_out    (scl_out),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .line_level (line_level)
);

// File: tb/test_sclk_line_ctrl.sv
module test_sclk_line_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] clk_cfg = '0;
    logic [3:0]  line_cfg = '0;
    logic        run = 1'b0;
    logic        seq_sda_out = 1'b0;
    logic        seq_sda_oe = 1'b0;
    logic        scl_in = 1'b1;
    logic        sda_in = 1'b1;
    logic        scl_out, scl_oe, sda_out, sda_oe;
    logic        scl_rise, scl_fall, launch;
    logic [1:0]  line_level;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sclk_line_ctrl i_sclk_line_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_cfg(clk_cfg), .line_cfg(line_cfg),
        .run(run), .seq_sda_out(seq_sda_out), .seq_sda_oe(seq_sda_oe),
        .scl_in(scl_in), .sda_in(sda_in), .scl_out(scl_out), .scl_oe(scl_oe),
        .sda_out(sda_out), .sda_oe(sda_oe), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .launch(launch), .line_level(line_level)
    );

    // each entry: {delay[2:0], divider[7:0]}, delay kept below 2*(div+1)
    localparam int NV = 5;
    localparam logic [10:0] VEC [NV] = '{
        {3'd1, 8'd0}, {3'd0, 8'd1}, {3'd3, 8'd2}, {3'd5, 8'd3}, {3'd7, 8'd4}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 scl_out", scl_out, 1);
        chk("R9 scl_rise", scl_rise, 0);
        chk("R9 scl_fall", scl_fall, 0);
        chk("R9 launch", launch, 0);
        chk("R9 line_level", line_level, 3);
        chk("R2 scl_oe idle", scl_oe, 0);
        rst_n = 1'b1;
        tick();

        // R1 R3 R4 R5 vector table
        for (int v = 0; v < NV; v++) begin
            int dv, ef, ff, sf, fr, fl, lowseen;
            dv = int'(VEC[v][7:0]);
            ef = (VEC[v][10:8] == 0) ? 1 : int'(VEC[v][10:8]);
            ff = -1; sf = -1; fr = -1; fl = -1; lowseen = 1;
            clk_cfg = VEC[v];
            run = 1'b1;
            for (int k = 1; k <= 3 * (dv + 1) + 10; k++) begin
                tick();
                if (scl_fall) begin
                    if (ff < 0) ff = k;
                    else if (sf < 0) sf = k;
                end
                if (scl_rise && fr < 0) fr = k;
                if (launch && fl < 0) fl = k;
                if (ff > 0 && fr < 0 && scl_out) lowseen = 0;
            end
            chk("R1 first fall", ff, dv + 1);
            chk("R1 R3 rise", fr, 2 * dv + 2);
            chk("R1 second fall", sf, 3 * dv + 3);
            chk("R4 R5 launch", fl, dv + 1 + ef);
            chk("R3 low between edges", lowseen, 1);
            run = 1'b0;
            tick();
            chk("R2 idle high", scl_out, 1);
            tick();
        end

        // R2 stop while low, restart counts from zero
        begin
            int ff;
            clk_cfg = {3'd1, 8'd3};
            run = 1'b1;
            repeat (6) tick();
            chk("R2 low before stop", scl_out, 0);
            run = 1'b0;
            tick();
            chk("R2 high after stop", scl_out, 1);
            chk("R2 scl_oe follows run", scl_oe, 0);
            chk("R3 no rise on idle", scl_rise, 0);
            ff = -1;
            run = 1'b1;
            for (int k = 1; k <= 8; k++) begin
                tick();
                if (scl_fall && ff < 0) ff = k;
            end
            chk("R2 restart first fall", ff, 4);
            chk("R2 scl_oe running", scl_oe, 1);
            run = 1'b0;
            tick();
        end

        // R7 SCL forcing, divider keeps running
        begin
            int nf;
            clk_cfg = {3'd1, 8'd1};
            run = 1'b1;
            line_cfg = 4'b0100;
            #1;
            chk("R7 forced low", scl_out, 0);
            chk("R7 forced oe", scl_oe, 1);
            nf = 0;
            for (int k = 1; k <= 8; k++) begin
                tick();
                if (scl_fall) nf++;
            end
            chk("R7 strobes continue", nf, 2);
            line_cfg = 4'b1100;
            #1;
            chk("R7 forced high", scl_out, 1);
            run = 1'b0;
            line_cfg = 4'b0100;
            #1;
            chk("R7 oe while idle", scl_oe, 1);
            line_cfg = 4'b0000;
            tick();
        end

        // R6 SDA forcing vs sequencer
        seq_sda_out = 1'b0; seq_sda_oe = 1'b0; line_cfg = 4'b0011;
        #1;
        chk("R6 forced sda value", sda_out, 1);
        chk("R6 forced sda oe", sda_oe, 1);
        seq_sda_out = 1'b1; seq_sda_oe = 1'b1; line_cfg = 4'b0001;
        #1;
        chk("R6 forced sda low", sda_out, 0);
        line_cfg = 4'b0010;
        #1;
        chk("R6 value bit ignored without enable", sda_out, 1);
        seq_sda_oe = 1'b0;
        #1;
        chk("R6 follows seq oe", sda_oe, 0);
        line_cfg = 4'b0000;
        tick();

        // R8 synchronized readback
        sda_in = 1'b0; scl_in = 1'b1;
        tick();
        chk("R8 one edge not yet", line_level, 3);
        tick();
        chk("R8 two edges sda low", line_level, 2);
        sda_in = 1'b1; scl_in = 1'b0;
        tick();
        tick();
        chk("R8 scl low", line_level, 1);
        scl_in = 1'b1;
        tick();
        tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule